// File: doc/BRIEF.md
# Clock-Stop SPI Master Serial Port

This block is the master side of a serial port run in clock-stop SPI mode. A single strobe starts a transfer that shifts one word out on the data-out pin and, at the same time, collects one word from the data-in pin. Between transfers the serial clock is held high and the select line is parked high. The data output is released to high impedance whenever no transfer is running.

The serial clock comes from a programmable rate generator. Its input is the system clock divided by two. An 8-bit divide value is captured when a transfer starts. It sets the clock period and also the split between high and low phases, which differs for odd and even values. Before the first falling clock edge, the select line drops and the most significant bit is presented for one high-phase time. After the last rising edge the clock stays high for one more high phase. The select line then returns high, the output floats, and a one-cycle done pulse is raised together with the received word.

Top module: `spi_stop_master`

## Requirements
- R1: While reset is held, and after it is released, ss_n is 1, sclk is 1, mosi_oe is 0, busy is 0 and done is 0.
- R2: For an even nonzero divide value d, each sclk high phase lasts d+2 system clock cycles and each low phase lasts d cycles, so one bit takes 2(d+1) cycles.
- R3: For d = 0 or an odd d, the high and low phases both last d+1 system clock cycles.
- R4: In the first cycle after an accepted start, ss_n is 0, mosi_oe is 1, mosi carries tx_word bit WORD_W-1 and sclk is still 1. sclk then stays high for one high-phase length before its first fall.
- R5: The transfer has exactly WORD_W rising sclk edges. The bits on mosi at these edges are tx_word, most significant bit first. mosi does not change in the cycle in which sclk rises.
- R6: miso is sampled at each rising sclk edge. The first bit sampled becomes rx_word bit WORD_W-1.
- R7: After the last rising edge, sclk stays high for one high-phase length. Then ss_n returns to 1, mosi_oe returns to 0, and done is high for exactly one cycle with rx_word updated. sclk is 1 whenever ss_n is 1.
- R8: A start strobe while busy has no effect. The data sent, the number of clock edges and the single done pulse are the same as without the strobe.
- R9: The divide value is captured at start. Changing clkgdv during a transfer does not change any phase length of that transfer.
- R10: busy is 1 from the cycle after an accepted start up to the cycle in which done is raised, and is 0 in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transfer request strobe, honoured only when idle |
| tx_word | input | WORD_W | Word to send, captured at start |
| clkgdv | input | DIV_W | Rate-generator divide value, captured at start |
| rx_word | output | WORD_W | Last received word, updated with done |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | Serial clock, idles high |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi, low means high impedance |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that start is a synchronous, single-cycle strobe. They also assume that miso only changes away from the system clock edge at which sclk rises. The bench's slave model meets both conditions: it drives start at the falling system clock edge, and it moves miso only after it has seen the rising serial clock. clkgdv is allowed to change at any time. The bench changes it on purpose in the middle of a transfer, to show that the captured value is the one that counts.

// File: rtl/spi_stop_master.sv
module spi_stop_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [DIV_W-1:0]  clkgdv,
  output logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              ss_n,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);

  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH} state_t;

  state_t            st;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  left;
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic              shift_pend;

  function automatic logic [CNT_W-1:0] hi_last(input logic [DIV_W-1:0] d);
    if (d != '0 && !d[0]) return CNT_W'(d) + CNT_W'(1);
    else                  return CNT_W'(d);
  endfunction

  function automatic logic [CNT_W-1:0] lo_last(input logic [DIV_W-1:0] d);
    if (d != '0 && !d[0]) return CNT_W'(d) - CNT_W'(1);
    else                  return CNT_W'(d);
  endfunction

  wire [CNT_W-1:0] hi_new = hi_last(clkgdv);
  wire [CNT_W-1:0] hi_cur = hi_last(div_q);
  wire [CNT_W-1:0] lo_cur = lo_last(div_q);

  assign busy    = (st != S_IDLE);
  assign ss_n    = (st == S_IDLE);
  assign mosi_oe = busy;
  assign sclk    = (st != S_LOW);
  assign mosi    = tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      div_q      <= '0;
      cnt        <= '0;
      left       <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_word    <= '0;
      done       <= 1'b0;
      shift_pend <= 1'b0;
    end else begin
      done       <= 1'b0;
      shift_pend <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          div_q <= clkgdv;
          tx_sh <= tx_word;
          cnt   <= hi_new;
          left  <= BIT_W'(WORD_W);
          st    <= S_LEAD;
        end
        S_LEAD: if (cnt == '0) begin
          cnt <= lo_cur;
          st  <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt == '0) begin
          rx_sh      <= WORD_W'({rx_sh, miso});
          left       <= left - 1'b1;
          shift_pend <= (left != BIT_W'(1));
          cnt        <= hi_cur;
          st         <= S_HIGH;
        end else cnt <= cnt - 1'b1;
        S_HIGH: begin
          if (shift_pend) tx_sh <= tx_sh << 1;
          if (cnt == '0) begin
            if (left == '0) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              rx_word <= rx_sh;
            end else begin
              cnt <= lo_cur;
              st  <= S_LOW;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_clock_parks_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> sclk);

  p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !mosi_oe && $past(!ss_n)));

  p_select_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(start));

  p_div_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |=> $stable(div_q));

  p_data_steady_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

endmodule

// File: tb/test_spi_stop_master.sv
module test_spi_stop_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_word = '0;
  logic [7:0] clkgdv = '0;
  logic [7:0] rx_word;
  logic       busy, done, sclk, ss_n, mosi, mosi_oe, miso;

  always #10 clk = ~clk;

  spi_stop_master #(.WORD_W(8), .DIV_W(8)) i_spi_stop_master (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .clkgdv(clkgdv),
    .rx_word(rx_word), .busy(busy), .done(done), .sclk(sclk), .ss_n(ss_n),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso));

  int checks = 0, failures = 0;
  logic [7:0] sl = '0, cap = '0;
  assign miso = sl[7];

  always @(posedge sclk) if (!ss_n) begin
    cap <= {cap[6:0], mosi};
    sl  <= sl << 1;
  end

  int lead, low, high, rises, hrun, tail, ss_cyc, mst, done_cnt;
  bit done_bad, oe_bad, busy_bad, pss, psclk;

  always @(negedge clk) begin
    if (!rst_n) begin
      pss = 1; psclk = 1; mst = 0; done_cnt = 0;
    end else begin
      if (!ss_n) begin
        if (pss) begin
          mst = 1; lead = 0; low = 0; high = 0; rises = 0; hrun = 0; ss_cyc = 0;
        end
        ss_cyc++;
        if (!mosi_oe) oe_bad = 1;
        if (!busy) busy_bad = 1;
        if (sclk) hrun++; else hrun = 0;
        if (sclk && !psclk) rises++;
        case (mst)
          1: if (sclk) lead++; else begin mst = 2; low = 1; end
          2: if (!sclk) low++; else begin mst = 3; high = 1; end
          3: if (sclk) high++; else mst = 4;
          default: ;
        endcase
      end else if (!pss) tail = hrun;
      if (done) begin
        done_cnt++;
        if (!ss_n || mosi_oe || busy) done_bad = 1;
      end
      pss = ss_n; psclk = sclk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] pat, input logic [7:0] d,
                      input logic [7:0] d_after, input bit poke, input string ptag);
    int h, l, n;
    if (d != 0 && !d[0]) begin h = d + 2; l = d; end
    else begin h = d + 1; l = d + 1; end
    sl = pat; cap = '0; done_cnt = 0; done_bad = 0; oe_bad = 0; busy_bad = 0;
    clkgdv = d; tx_word = tx;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    clkgdv = d_after;
    check(ss_n == 0, "R4 select low", ss_n, 0);
    check(mosi_oe == 1 && mosi == tx[7], "R4 first bit driven", {mosi_oe, mosi}, {1'b1, tx[7]});
    check(sclk == 1, "R4 clock high at select", sclk, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      tx_word = ~tx; start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    check(n < 20000, "R7 done reached", n, 0);
    repeat (4) @(negedge clk);
    check(lead == h, "R4 lead phase", lead, h);
    check(low == l, {ptag, " low phase"}, low, l);
    check(high == h, {ptag, " high phase"}, high, h);
    check(ss_cyc == h + 8 * (l + h), {ptag, " select length"}, ss_cyc, h + 8 * (l + h));
    check(rises == 8, "R5 rising edges", rises, 8);
    check(cap == tx, "R5 MSB-first data", cap, tx);
    check(rx_word == pat, "R6 received word", rx_word, pat);
    check(tail == h, "R7 tail high phase", tail, h);
    check(done_cnt == 1 && !done_bad, "R7 single done at release", done_cnt, 1);
    check(ss_n && sclk && !mosi_oe, "R7 idle pins", {ss_n, sclk, mosi_oe}, 3'b110);
    check(!oe_bad && !busy_bad && !busy, "R10 busy and enable span", busy, 0);
    if (poke) check(cap == tx && done_cnt == 1, "R8 start ignored while busy", cap, tx);
    if (d != d_after) check(low == l && high == h, "R9 divide captured", low, l);
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ss_n && sclk && !mosi_oe && !busy && !done, "R1 in reset",
          {ss_n, sclk, mosi_oe, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ss_n && sclk && !mosi_oe && !busy && !done, "R1 after reset",
          {ss_n, sclk, mosi_oe, busy, done}, 5'b11000);
  endtask

  bit finished = 0;

  initial begin
    reset_test();
    xfer(8'hA5, 8'h3C, 8'd0,   8'd0,   0, "R3");
    xfer(8'h81, 8'hC3, 8'd1,   8'd1,   0, "R3");
    xfer(8'h5A, 8'h96, 8'd2,   8'd2,   0, "R2");
    xfer(8'hF0, 8'h0F, 8'd5,   8'd5,   0, "R3");
    xfer(8'h01, 8'h80, 8'd254, 8'd254, 0, "R2");
    xfer(8'h6E, 8'hB1, 8'd4,   8'd1,   0, "R2");
    xfer(8'hC9, 8'h27, 8'd3,   8'd3,   1, "R3");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule